// File: doc/BRIEF.md
# Realigning DMA Staging Buffer

This block sits between the read side and the write side of a DMA engine. The read side hands it full 64-bit words. The block keeps them as a byte stream in a circular buffer of sixteen words, which is 128 bytes. The write side takes the data out as words whose bytes have been moved to match the low three bits of the destination address. Every output word carries byte enables, so a partial head word or tail word writes only the bytes that hold data.

A transfer begins with a one-cycle `start` pulse. That pulse clears the buffer and captures the destination byte offset, which then stays fixed for the whole transfer. The block does not request a write as soon as any data is present. It raises `dst_req` only in three cases:

- the head word is misaligned and enough bytes are stored to fill it;
- more than half of the buffer is occupied;
- the read side has pulsed `src_done`. From then on the block keeps requesting until every remaining byte has been written out, including a final partial word.

Top module: `dma_align_fifo`

## Requirements
- R1: After reset, `dst_req` is 0 and `src_ready` is 1.
- R2: The buffer holds 128 bytes. `src_ready` is 1 exactly when `start` is low and at least 8 bytes are free, so sixteen words are accepted with no write in between and then `src_ready` falls.
- R3: When the captured offset is 0 and `src_done` has not been seen, `dst_req` is 1 exactly when more than 64 bytes are stored.
- R4: When the captured offset k is nonzero, the head word is still pending and at least 8-k bytes are stored, `dst_req` is 1.
- R5: The head word of a transfer with offset k puts its bytes in lanes k..7. Its `dst_be` has bits k..7 set and bits below k clear. Lane i is `dst_data[8i+7:8i]` and is enabled by `dst_be[i]`.
- R6: Every word after the head word starts at lane 0.
- R7: After a `src_done` pulse, `dst_req` stays 1 while any byte remains. The last word is partial and enables only its low lanes.
- R8: Bytes leave in the order they arrived. Byte j of `src_data` (bits 8j+7:8j) comes before byte j+1, and words leave in the order they were accepted.
- R9: The offset is captured only in a cycle with `start` high. Changes to `start_offset` at any other time have no effect on lanes or enables.
- R10: `dst_ack` pulsed while `dst_req` is 0 removes no data. After the buffer drains, `dst_req` is 0.
- R11: A word offered on `src_valid` while `src_ready` is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer: clear the buffer and capture the offset |
| start_offset | input | 3 | Destination byte offset, captured with `start` |
| src_valid | input | 1 | Read side offers a word |
| src_ready | output | 1 | Room for one full word |
| src_data | input | 64 | Offered word, byte 0 in the low bits |
| src_done | input | 1 | Pulse: no more read data for this transfer |
| dst_req | output | 1 | Destination write request |
| dst_ack | input | 1 | Write side accepts the current word |
| dst_data | output | 64 | Realigned output word |
| dst_be | output | 8 | Byte enables of the output word |

## Verification
The bench runs transfers at every kind of offset: zero, one, mid-range and seven. A shifter with an off-by-one lane error or a swapped direction would fail the head-word enable and data checks. The bench checks the request line in every cycle while the buffer fills. A threshold compare written as at-or-above instead of strictly above would raise the request one word early at offset 0. A missing misaligned-head condition would leave an offset-7 transfer with two words stalled until `src_done`.

The bench also fills the buffer completely and then offers one more word. A design that overwrites the oldest data would then put foreign bytes into the drained stream. The bench acknowledges while no request is up, which catches a design that pops on a bare acknowledge. It changes `start_offset` after the start pulse, which catches a design that shifts by the live input instead of the captured offset.

// File: rtl/dafq_pkg.sv
package dafq_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dafq_byte_ring.sv
// Circular byte store: writes one whole word per push, reads a word-wide window at the head.
module dafq_byte_ring
    import dafq_pkg::*;
#(
    parameter int unsigned WB        = 8,
    parameter int unsigned BUF_BYTES = 128,
    parameter int unsigned PTR_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WB*8-1:0]   wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WB*8-1:0]   rd_window
);
    byte_t mem_d [BUF_BYTES];
    byte_t mem_q [BUF_BYTES];

    always_comb begin
        logic [PTR_W-1:0] idx;
        mem_d = mem_q;
        if (wr_en) begin
            for (int b = 0; b < int'(WB); b++) begin
                idx = wr_ptr + PTR_W'(b);
                mem_d[idx] = wr_data[8*b +: 8];
            end
        end
        for (int b = 0; b < int'(WB); b++) begin
            idx = rd_ptr + PTR_W'(b);
            rd_window[8*b +: 8] = mem_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(BUF_BYTES); i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/dafq_aligner.sv
// Barrel shift of the head window up by start_lane, with enables for beat_n bytes.
module dafq_aligner #(
    parameter int unsigned WB     = 8,
    parameter int unsigned LANE_W = 3
) (
    input  logic [WB*8-1:0]   window,
    input  logic [LANE_W-1:0] start_lane,
    input  logic [LANE_W:0]   beat_n,
    output logic [WB*8-1:0]   data,
    output logic [WB-1:0]     be
);
    always_comb begin
        int rel;
        data = '0;
        be   = '0;
        for (int l = 0; l < int'(WB); l++) begin
            rel = l - int'(start_lane);
            if (rel >= 0 && rel < int'(beat_n)) begin
                data[8*l +: 8] = window[8*rel +: 8];
                be[l]          = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dafq_ctrl.sv
// Pointers, fill level, captured offset and the write-request decision.
module dafq_ctrl #(
    parameter int unsigned WB        = 8,
    parameter int unsigned BUF_BYTES = 128,
    parameter int unsigned PTR_W     = 7,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned LANE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANE_W-1:0] start_offset,
    input  logic              src_valid,
    input  logic              src_done,
    input  logic              dst_ack,
    output logic              src_ready,
    output logic              push,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [LANE_W-1:0] start_lane,
    output logic [LANE_W:0]   beat_n,
    output logic              dst_req
);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(BUF_BYTES / 2);
    localparam logic [CNT_W-1:0] ROOM_C = CNT_W'(BUF_BYTES - WB);
    localparam logic [CNT_W-1:0] WB_C   = CNT_W'(WB);

    typedef struct packed {
        logic [PTR_W-1:0]  head;
        logic [CNT_W-1:0]  count;
        logic              first;
        logic              done;
        logic [LANE_W-1:0] offset;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [LANE_W:0] room;
    logic            head_ok;
    logic            pop;

    always_comb begin
        start_lane = st_q.first ? st_q.offset : '0;
        room       = (LANE_W+1)'(WB) - {1'b0, start_lane};
        beat_n     = (st_q.count < CNT_W'(room)) ? st_q.count[LANE_W:0] : room;
        head_ok    = st_q.first && (st_q.offset != '0) && (st_q.count >= CNT_W'(room));
        dst_req    = (st_q.count != '0) && (head_ok || (st_q.count > HALF_C) || st_q.done);
        src_ready  = !start && (st_q.count <= ROOM_C);
        push       = src_valid && src_ready;
        pop        = dst_req && dst_ack;
        wr_ptr     = st_q.head + st_q.count[PTR_W-1:0];
        rd_ptr     = st_q.head;

        st_d = st_q;
        if (start) begin
            st_d.count  = '0;
            st_d.first  = 1'b1;
            st_d.done   = 1'b0;
            st_d.offset = start_offset;
        end else begin
            st_d.count = st_q.count + (push ? WB_C : '0) - (pop ? CNT_W'(beat_n) : '0);
            if (pop) begin
                st_d.head  = st_q.head + PTR_W'(beat_n);
                st_d.first = 1'b0;
            end
            if (src_done) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{head: '0, count: '0, first: 1'b1, done: 1'b0, offset: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CNT_W'(BUF_BYTES)); // R2
    AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (rst)
        (st_q.count > HALF_C) |-> dst_req); // R3
    AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        dst_req |-> (st_q.count != '0)); // R10
    AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(st_q.offset)); // R9
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (st_q.count > ROOM_C) |-> !src_ready); // R11
endmodule

// File: rtl/dma_align_fifo.sv
module dma_align_fifo #(
    parameter int unsigned DEPTH_WORDS = 16,
    parameter int unsigned WORD_BYTES  = 8,
    localparam int unsigned LANE_W     = $clog2(WORD_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LANE_W-1:0]       start_offset,
    input  logic                    src_valid,
    output logic                    src_ready,
    input  logic [WORD_BYTES*8-1:0] src_data,
    input  logic                    src_done,
    output logic                    dst_req,
    input  logic                    dst_ack,
    output logic [WORD_BYTES*8-1:0] dst_data,
    output logic [WORD_BYTES-1:0]   dst_be
);
    localparam int unsigned BUF_BYTES = DEPTH_WORDS * WORD_BYTES;
    localparam int unsigned PTR_W     = $clog2(BUF_BYTES);
    localparam int unsigned CNT_W     = $clog2(BUF_BYTES + 1);

    logic                    push;
    logic [PTR_W-1:0]        wr_ptr;
    logic [PTR_W-1:0]        rd_ptr;
    logic [LANE_W-1:0]       start_lane;
    logic [LANE_W:0]         beat_n;
    logic [WORD_BYTES*8-1:0] window;

    dafq_ctrl #(
        .WB(WORD_BYTES), .BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W),
        .CNT_W(CNT_W), .LANE_W(LANE_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_offset(start_offset),
        .src_valid(src_valid), .src_done(src_done), .dst_ack(dst_ack),
        .src_ready(src_ready), .push(push), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .start_lane(start_lane), .beat_n(beat_n), .dst_req(dst_req)
    );

    dafq_byte_ring #(
        .WB(WORD_BYTES), .BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)
    ) u_ring (
        .clk(clk), .rst(rst), .wr_en(push), .wr_ptr(wr_ptr),
        .wr_data(src_data), .rd_ptr(rd_ptr), .rd_window(window)
    );

    dafq_aligner #(
        .WB(WORD_BYTES), .LANE_W(LANE_W)
    ) u_align (
        .window(window), .start_lane(start_lane), .beat_n(beat_n),
        .data(dst_data), .be(dst_be)
    );

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dst_req |-> (dst_be != '0)); // R7
    AST_BE_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        dst_req |-> ((dst_be & ((WORD_BYTES'(1) << start_lane) - WORD_BYTES'(1))) == '0)); // R5
endmodule

// File: tb/dma_align_fifo_bench.sv
module dma_align_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;
    localparam logic [2:0] VEC_OFF   [N_VEC] = '{3'd0, 3'd3, 3'd7, 3'd1, 3'd5, 3'd0};
    localparam int         VEC_BEATS [N_VEC] = '{12, 10, 2, 16, 1, 3};
    localparam logic [7:0] VEC_BE0   [N_VEC] = '{8'hFF, 8'hF8, 8'h80, 8'hFE, 8'hE0, 8'hFF};

    logic        clk = 0;
    logic        rst, start, src_valid, src_done, dst_ack;
    logic [2:0]  start_offset;
    logic [63:0] src_data;
    logic        src_ready, dst_req;
    logic [63:0] dst_data;
    logic [7:0]  dst_be;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [7:0] model[$];
    bit         m_first, m_done;
    int         m_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_align_fifo u_dma_align_fifo (
        .clk(clk), .rst(rst), .start(start), .start_offset(start_offset),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .src_done(src_done), .dst_req(dst_req), .dst_ack(dst_ack),
        .dst_data(dst_data), .dst_be(dst_be)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit exp_req();
        int c = model.size();
        return (c != 0) && ((m_first && m_off != 0 && c >= 8 - m_off) || c > 64 || m_done);
    endfunction

    task automatic run_vec(input int e);
        int off = int'(VEC_OFF[e]);
        bit head_seen = 0;
        @(negedge clk);
        start = 1; start_offset = VEC_OFF[e];
        @(posedge clk);
        model.delete(); m_first = 1; m_done = 0; m_off = off;
        @(negedge clk);
        start = 0; start_offset = ~VEC_OFF[e]; // R9: live input changes after capture
        for (int k = 0; k < VEC_BEATS[e]; k++) begin
            logic [63:0] w;
            bit er;
            for (int b = 0; b < 8; b++) w[8*b +: 8] = 8'(e*64 + k*8 + b + 1);
            src_valid = 1; src_data = w;
            er = exp_req();
            dst_ack = !er; // R10: acknowledge without request must be ignored
            #1;
            check(src_ready == (model.size() <= 120), "R2 ready", 64'(src_ready), 64'(model.size() <= 120));
            check(dst_req == er, (off == 0) ? "R3 level request" : "R4 misaligned request", 64'(dst_req), 64'(er));
            @(posedge clk);
            for (int b = 0; b < 8; b++) model.push_back(w[8*b +: 8]);
            @(negedge clk);
        end
        src_valid = 0; dst_ack = 0;
        if (model.size() > 120) begin
            src_valid = 1; src_data = 64'hDEAD_BEEF_DEAD_BEEF; // R11: offered while full
            #1;
            check(src_ready == 0, "R2 full", 64'(src_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
            src_valid = 0;
        end
        src_done = 1;
        @(posedge clk);
        m_done = 1;
        @(negedge clk);
        src_done = 0;
        while (model.size() > 0) begin
            int st, n;
            logic [63:0] ed;
            logic [7:0] eb;
            st = m_first ? m_off : 0;
            n = (model.size() < 8 - st) ? model.size() : 8 - st;
            ed = '0; eb = '0;
            for (int l = st; l < st + n; l++) begin
                ed[8*l +: 8] = model[l - st];
                eb[l] = 1'b1;
            end
            dst_ack = 1;
            #1;
            check(dst_req == 1, "R7 flush request", 64'(dst_req), 64'd1);
            check(dst_be == eb, m_first ? "R5 head enables" : (n < 8 ? "R7 tail enables" : "R6 full enables"), 64'(dst_be), 64'(eb));
            check((dst_data & {{8{eb[7]}},{8{eb[6]}},{8{eb[5]}},{8{eb[4]}},{8{eb[3]}},{8{eb[2]}},{8{eb[1]}},{8{eb[0]}}}) == ed,
                  "R8 byte order", dst_data, ed);
            if (!head_seen) begin
                check(dst_be == VEC_BE0[e], "R5 head table", 64'(dst_be), 64'(VEC_BE0[e]));
                head_seen = 1;
            end
            @(posedge clk);
            for (int i = 0; i < n; i++) void'(model.pop_front());
            m_first = 0;
            @(negedge clk);
        end
        dst_ack = 0;
        #1;
        check(dst_req == 0, "R10 drained", 64'(dst_req), 64'd0);
    endtask

    initial begin
        rst = 1; start = 0; start_offset = 0; src_valid = 0; src_done = 0; dst_ack = 0; src_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check(dst_req == 0, "R1 reset req", 64'(dst_req), 64'd0);
        check(src_ready == 1, "R1 reset ready", 64'(src_ready), 64'd1);
        for (int e = 0; e < N_VEC; e++) run_vec(e);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule